// File: doc/BRIEF.md
# Two-Level Route Lookup Engine

This block finds the next hop for a destination address by longest-prefix match, using at most two table reads. The upper bits of the address index a first-level table directly. Each first-level entry either holds the next hop itself or names a block of 256 second-level entries. Routes longer than the first-level index are expanded into such a block, and the low 8 address bits then select the entry within it. Software performs the prefix expansion and loads both tables through separate write ports. The engine only performs lookups.

The pipeline accepts one address per clock and returns results in the order the addresses arrived. Both paths take the same fixed latency, so a direct first-level hit never overtakes a lookup that needs the second-level read. The index width is a parameter. The default is small for simulation, and a value of 24 gives the full 32-bit address split of 24 index bits plus 8 offset bits. The number of second-level blocks is also a parameter.

Top module: `route_lookup`

## Requirements
- R1: After reset, every first-level entry acts as a direct hop of value 0 and every second-level entry holds 0, so any lookup returns next hop 0. `out_valid` is low after reset until a lookup has been accepted.
- R2: A first-level entry written with `l1_wr_is_hop`=1 returns `l1_wr_data` as the next hop for every address whose upper L1W bits equal its index.
- R3: A first-level entry written with `l1_wr_is_hop`=0 is a block pointer. Its low L2BW data bits form the base, and the result is the second-level entry at address {base, in_addr[7:0]}.
- R4: Each result appears on `out_valid`/`out_hop` exactly two clock edges after its address was sampled with `in_valid`=1. The latency is the same for the direct path and the pointer path.
- R5: A new address is accepted every cycle, and results come out in acceptance order, including mixed direct and pointer lookups.
- R6: A first-level write in the same cycle as a lookup that reads the same index gives that lookup the old entry. The next lookup sees the new entry.
- R7: A second-level write in the cycle when a lookup reads that entry (the cycle after the lookup's address was accepted) gives that lookup the old value.
- R8: `out_valid` is high only for accepted lookups; an idle input gives no result.
- R9: Addresses that share a pointer entry but differ in their low 8 bits select different second-level entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address present this cycle |
| in_addr | input | L1W+8 | Destination address |
| l1_wr_en | input | 1 | First-level table write strobe |
| l1_wr_idx | input | L1W | First-level entry index |
| l1_wr_is_hop | input | 1 | 1: data is a next hop, 0: data is a block base |
| l1_wr_data | input | NHW | Next hop or block base |
| l2_wr_en | input | 1 | Second-level table write strobe |
| l2_wr_addr | input | L2BW+8 | Second-level entry address {block, offset} |
| l2_wr_hop | input | NHW | Next hop stored in that entry |
| out_valid | output | 1 | Result present |
| out_hop | output | NHW | Next hop of the longest matching prefix |

## Verification
A corrupted flag or base in a first-level entry shows up two cycles after the first lookup that touches it. It appears as a wrong hop on every address in that range. If the base is wrong, the hops come from another block. A broken pipeline valid or a mismatched path latency shows up as a missing, spurious or reordered result in a back-to-back stream. The scoreboard catches this on the next output, because it also checks the cycle of each result. A write-ordering fault changes only the result of the lookup issued in the same cycle as the write, so those collisions are driven on purpose for both tables.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int OFFW = 8;   // second-level offset width
    localparam int NHW  = 8;   // next-hop width

    typedef struct packed {
        logic            is_hop;  // 1: data is a next hop, 0: block base
        logic [NHW-1:0]  data;
    } l1_entry_t;

    localparam l1_entry_t L1_DEFAULT = '{is_hop: 1'b1, data: '0};

    typedef struct packed {
        logic             valid;
        logic [OFFW-1:0]  off;
    } stage1_t;

    typedef struct packed {
        logic            valid;
        logic            is_hop;
        logic [NHW-1:0]  hop;
    } stage2_t;

    function automatic logic [NHW-1:0] pick_hop(input logic is_hop,
                                                input logic [NHW-1:0] direct,
                                                input logic [NHW-1:0] second);
        return is_hop ? direct : second;
    endfunction
endpackage

// File: rtl/rle_ram.sv
module rle_ram #(
    parameter int          AW      = 8,
    parameter int          DW      = 9,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Registered read sees the array before this edge's write lands.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
            rd_data <= RST_VAL;
        end else begin
            if (wr_en) mem[wr_addr] <= wr_data;
            rd_data <= mem[rd_addr];
        end
    end

    // R6 and R7: a written word is present in the array one cycle later
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/route_lookup.sv
module route_lookup
    import rle_pkg::*;
#(
    parameter int L1W  = 8,
    parameter int L2BW = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [L1W+OFFW-1:0]    in_addr,
    input  logic                   l1_wr_en,
    input  logic [L1W-1:0]         l1_wr_idx,
    input  logic                   l1_wr_is_hop,
    input  logic [NHW-1:0]         l1_wr_data,
    input  logic                   l2_wr_en,
    input  logic [L2BW+OFFW-1:0]   l2_wr_addr,
    input  logic [NHW-1:0]         l2_wr_hop,
    output logic                   out_valid,
    output logic [NHW-1:0]         out_hop
);
    localparam int AW   = L1W + OFFW;
    localparam int L2AW = L2BW + OFFW;
    localparam int L1DW = $bits(l1_entry_t);

    initial begin
        if (L2BW > NHW) $error("block base wider than entry data");
    end

    l1_entry_t        l1_q;
    logic [L1DW-1:0]  l1_raw;
    logic [NHW-1:0]   l2_q;
    stage1_t          s1;
    stage2_t          s2;
    logic [L2AW-1:0]  l2_rd_addr;

    // First read: direct index by upper address bits
    rle_ram #(.AW(L1W), .DW(L1DW), .RST_VAL(L1_DEFAULT)) u_l1 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (l1_wr_en),
        .wr_addr (l1_wr_idx),
        .wr_data ({l1_wr_is_hop, l1_wr_data}),
        .rd_addr (in_addr[AW-1 -: L1W]),
        .rd_data (l1_raw)
    );
    assign l1_q = l1_entry_t'(l1_raw);

    always_ff @(posedge clk) begin
        if (rst) s1 <= '0;
        else     s1 <= '{valid: in_valid, off: in_addr[OFFW-1:0]};
    end

    // Second read: block base from the entry plus offset bits
    assign l2_rd_addr = {l1_q.data[L2BW-1:0], s1.off};

    rle_ram #(.AW(L2AW), .DW(NHW), .RST_VAL('0)) u_l2 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (l2_wr_en),
        .wr_addr (l2_wr_addr),
        .wr_data (l2_wr_hop),
        .rd_addr (l2_rd_addr),
        .rd_data (l2_q)
    );

    // Direct hop rides alongside the second read so both paths align
    always_ff @(posedge clk) begin
        if (rst) s2 <= '0;
        else     s2 <= '{valid: s1.valid, is_hop: l1_q.is_hop, hop: l1_q.data};
    end

    assign out_valid = s2.valid;
    assign out_hop   = pick_hop(s2.is_hop, s2.hop, l2_q);

    a_r4_two_cycle: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    a_r2_direct_hop: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && l1_q.is_hop) |=> out_hop == $past(l1_q.data));
endmodule

// File: tb/route_lookup_test.sv
module route_lookup_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_addr;
    logic        l1_wr_en;
    logic [7:0]  l1_wr_idx;
    logic        l1_wr_is_hop;
    logic [7:0]  l1_wr_data;
    logic        l2_wr_en;
    logic [10:0] l2_wr_addr;
    logic [7:0]  l2_wr_hop;
    logic        out_valid;
    logic [7:0]  out_hop;

    always #10 clk = ~clk;  // 50 MHz

    route_lookup #(.L1W(8), .L2BW(3)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .l1_wr_en(l1_wr_en), .l1_wr_idx(l1_wr_idx), .l1_wr_is_hop(l1_wr_is_hop),
        .l1_wr_data(l1_wr_data), .l2_wr_en(l2_wr_en), .l2_wr_addr(l2_wr_addr),
        .l2_wr_hop(l2_wr_hop), .out_valid(out_valid), .out_hop(out_hop)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Requirement model of both tables
    logic [8:0] l1m [256];
    logic [7:0] l2m [2048];

    logic [7:0] exp_q [$];
    string      tag_q [$];
    int         cyc_q [$];

    bit         pend_v = 0;
    bit         pend_f;
    logic [7:0] pend_d;
    logic [7:0] pend_off;
    string      pend_tag;
    int         pend_cyc;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input bit lv, input logic [15:0] a, input string tag,
                        input bit w1, input logic [7:0] w1i, input bit w1f,
                        input logic [7:0] w1d, input bit w2,
                        input logic [10:0] w2a, input logic [7:0] w2d);
        @(negedge clk);
        if (pend_v) begin
            exp_q.push_back(pend_f ? pend_d : l2m[{pend_d[2:0], pend_off}]);
            tag_q.push_back(pend_tag);
            cyc_q.push_back(pend_cyc + 2);
        end
        pend_v = lv;
        if (lv) begin
            pend_f   = l1m[a[15:8]][8];
            pend_d   = l1m[a[15:8]][7:0];
            pend_off = a[7:0];
            pend_tag = tag;
            pend_cyc = cyc;
        end
        if (w1) l1m[w1i] = {w1f, w1d};
        if (w2) l2m[w2a] = w2d;
        in_valid     = lv;
        in_addr      = a;
        l1_wr_en     = w1;
        l1_wr_idx    = w1i;
        l1_wr_is_hop = w1f;
        l1_wr_data   = w1d;
        l2_wr_en     = w2;
        l2_wr_addr   = w2a;
        l2_wr_hop    = w2d;
    endtask

    task automatic look(input logic [15:0] a, input string tag);
        step(1, a, tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle();
        step(0, 0, "", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr1(input logic [7:0] i, input bit f, input logic [7:0] d);
        step(0, 0, "", 1, i, f, d, 0, 0, 0);
    endtask

    task automatic wr2(input logic [10:0] a, input logic [7:0] d);
        step(0, 0, "", 0, 0, 0, 0, 1, a, d);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8: result without lookup, actual hop=%0h expected none", out_hop);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string      t = tag_q.pop_front();
                    automatic int         c = cyc_q.pop_front();
                    if (out_hop !== e) begin
                        errors++;
                        $display("FAIL %s: hop actual=%0h expected=%0h", t, out_hop, e);
                    end
                    checks++;
                    if (cyc != c) begin
                        errors++;
                        $display("FAIL R4: result cycle actual=%0d expected=%0d", cyc, c);
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) l1m[i] = 9'h100;
        for (int i = 0; i < 2048; i++) l2m[i] = 8'h00;
        rst = 1'b1;
        in_valid = 0; in_addr = 0; l1_wr_en = 0; l1_wr_idx = 0; l1_wr_is_hop = 0;
        l1_wr_data = 0; l2_wr_en = 0; l2_wr_addr = 0; l2_wr_hop = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        #1;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid after reset actual=%b expected=0", out_valid);
        end

        // R1: default route everywhere
        look(16'h1234, "R1");
        look(16'hFFFF, "R1");
        look(16'h80FF, "R1");

        // R2: direct hops
        wr1(8'h12, 1, 8'h5A);
        wr1(8'h40, 1, 8'h77);
        look(16'h12AB, "R2");
        look(16'h4000, "R2");
        look(16'h40FF, "R2");

        // R3 and R9: pointer entry to block 3
        wr1(8'h80, 0, 8'h03);
        wr2(11'h310, 8'h21);
        wr2(11'h3FF, 8'h22);
        look(16'h8010, "R3");
        look(16'h80FF, "R3");
        look(16'h8011, "R9");
        wr2(11'h311, 8'h23);
        look(16'h8011, "R9");

        // R5: back-to-back mixed stream
        for (int i = 0; i < 16; i++) begin
            if (i % 3 == 0)      look(16'h1200 | 16'(i), "R5");
            else if (i % 3 == 1) look(16'h8010, "R5");
            else                 look(16'h80FF, "R5");
        end

        // R6: first-level write collides with a lookup of the same index
        step(1, 16'h4000, "R6", 1, 8'h40, 1, 8'h99, 0, 0, 0);
        look(16'h4001, "R6");

        // R7: second-level write lands in the cycle the entry is read
        look(16'h8010, "R7");
        step(1, 16'h8010, "R7", 0, 0, 0, 0, 1, 11'h310, 8'h31);
        idle();

        // R8: idle input, no results
        repeat (6) idle();
        #1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: pending results actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule